// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog. A 7-bit down-counter is advanced by a clock-enable chain. The chain is a fixed divider (nominally 4096 bus clocks) followed by a selectable power-of-two stage of 1, 2, 4 or 8. Once armed, the block issues a one-cycle system reset request in three cases:

- the counter's top bit drops, which is the step from 0x40 to 0x3F;
- software reloads the counter with a value whose top bit is zero;
- software reloads the counter while it is still above a programmed window limit.

A sticky early-warning flag marks the arrival of the counter at 0x40. If software has opened the warning interrupt, the flag drives an interrupt line.

Software reaches three word registers through a simple single-cycle bus. A write is a cycle with `bus_sel` and `bus_wr` high. Read data is combinational from `bus_addr`. A normal service loop works in four steps:

1. Arm the watchdog.
2. Set the window limit and the divide ratio.
3. Wait until the counter has fallen to or below the limit.
4. Reload it with a value of 0x40 or more.

The reset controller that consumes `rst_req` is outside this block.

Top module: `wdog_window`

## Requirements
- R1: After reset, offset 0x0 (control: bit 7 armed, bits 6:0 count) reads 0x7F. Offset 0x4 (setup: bit 9 warning-interrupt enable, bits 8:7 divide select, bits 6:0 window limit) reads 0x7F. Offset 0x8 (bit 0 warning flag) reads 0. Any other offset reads 0. `rst_req` and `ewi_irq` are low.
- R2: The count decreases by exactly one every BASE_DIV × 2^S bus clocks, where S is the divide select (0 to 3). It wraps from 0x00 to 0x7F.
- R3: Writing 1 to control bit 7 arms the watchdog. Writing 0 there leaves the armed state unchanged; only reset disarms it.
- R4: While armed, the step from 0x40 to 0x3F raises `rst_req` for one cycle, in the same cycle the count first reads 0x3F.
- R5: While armed (or armed by the same write), a control write whose bit 6 is 0 is accepted. `rst_req` rises in the cycle after the write edge.
- R6: While armed, a control write made when the current count is above the window limit raises `rst_req` and leaves the count not loaded. A write made when the count equals or is below the limit loads the count and raises nothing.
- R7: While not armed, the count still decreases and accepts any written value, and `rst_req` never rises.
- R8: The warning flag (status bit 0) sets when the count decreases to 0x40, whether or not the interrupt is enabled and whether or not the watchdog is armed.
- R9: A status write with bit 0 equal to 0 clears the warning flag. A status write with bit 0 equal to 1 leaves it unchanged.
- R10: The warning-interrupt enable (setup bit 9) is set by writing 1 and cleared only by reset. `ewi_irq` is high exactly while the enable and the warning flag are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| rst_req | output | 1 | One-cycle system reset request |
| ewi_irq | output | 1 | Early-warning interrupt |

## Verification
The divider is measured under all four divide selects, with the period checked one cycle early and exactly on time. This separates a correct ratio from an off-by-one divider or a wrong power of two. Reloads are applied in four cases, and each must be told apart from the others:

- count above the limit (reject plus request);
- count exactly equal to the limit (accept, the boundary);
- a value below 0x40 (accept plus request);
- the same patterns while disarmed (never a request).

The natural 0x40-to-0x3F crossing is run both armed and disarmed. This shows that the request is gated only by the armed state, and that the warning flag does not depend on either enable.

// File: rtl/wdog_window_pkg.sv
package wdog_window_pkg;

    localparam int CNT_W  = 7;
    localparam int PSC_W  = 2;
    localparam int POST_W = (1 << PSC_W) - 1;

    // byte offsets (software visible)
    localparam int OFFS_CTRL = 'h0;
    localparam int OFFS_CFG  = 'h4;
    localparam int OFFS_STAT = 'h8;

    // field positions
    localparam int CTRL_EN_BIT = CNT_W;
    localparam int CFG_PSC_LO  = CNT_W;
    localparam int CFG_EWI_BIT = CNT_W + PSC_W;
    localparam int STAT_FLAG   = 0;

    localparam logic [CNT_W-1:0] CNT_TOP    = '1;
    localparam logic [CNT_W-1:0] CNT_THRESH = CNT_W'(1 << (CNT_W - 1));

    typedef struct packed {
        logic             ewi;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] win;
    } setup_t;

    typedef struct packed {
        logic             load;
        logic             arm;
        logic [CNT_W-1:0] value;
    } reload_t;

    // mask of the post-divider bits that must all be ones for a tick
    function automatic logic [POST_W-1:0] post_mask(input logic [PSC_W-1:0] sel);
        logic [POST_W-1:0] m;
        for (int i = 0; i < POST_W; i++) begin
            m[i] = (i < int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_window_pkg::*;
#(
    parameter int BASE_DIV = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic base_pulse;

    generate
        if (BASE_DIV <= 1) begin : g_nodiv
            assign base_pulse = 1'b1;
        end else begin : g_div
            localparam int BW = $clog2(BASE_DIV);
            logic [BW-1:0] base_q;
            assign base_pulse = (base_q == BW'(BASE_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)             base_q <= '0;
                else if (base_pulse) base_q <= '0;
                else                 base_q <= base_q + 1'b1;
            end
        end
    endgenerate

    logic [POST_W-1:0] post_q;
    logic [POST_W-1:0] mask;

    always_comb begin
        mask = post_mask(psc);
        tick = base_pulse && ((post_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst)             post_q <= '0;
        else if (base_pulse) post_q <= post_q + 1'b1;
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_window_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag_set,
    output reload_t           reload,
    output logic              armed,
    output setup_t            setup,
    output logic              flag
);

    logic ctrl_wr, cfg_wr, stat_wr;

    always_comb begin
        ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFFS_CTRL));
        cfg_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFFS_CFG));
        stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFFS_STAT));
        reload.load  = ctrl_wr;
        reload.arm   = bus_wdata[CTRL_EN_BIT];
        reload.value = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            setup.ewi <= 1'b0;
            setup.psc <= '0;
            setup.win <= CNT_TOP;
            flag      <= 1'b0;
        end else begin
            if (ctrl_wr && bus_wdata[CTRL_EN_BIT]) armed <= 1'b1;
            if (cfg_wr) begin
                if (bus_wdata[CFG_EWI_BIT]) setup.ewi <= 1'b1;
                setup.psc <= bus_wdata[CFG_PSC_LO +: PSC_W];
                setup.win <= bus_wdata[CNT_W-1:0];
            end
            if (flag_set)                              flag <= 1'b1;
            else if (stat_wr && !bus_wdata[STAT_FLAG]) flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFFS_CTRL)) begin
            bus_rdata[CTRL_EN_BIT] = armed;
            bus_rdata[CNT_W-1:0]   = cnt;
        end else if (bus_addr == ADDR_W'(OFFS_CFG)) begin
            bus_rdata[CFG_EWI_BIT]         = setup.ewi;
            bus_rdata[CFG_PSC_LO +: PSC_W] = setup.psc;
            bus_rdata[CNT_W-1:0]           = setup.win;
        end else if (bus_addr == ADDR_W'(OFFS_STAT)) begin
            bus_rdata[STAT_FLAG] = flag;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:CFG_EWI_BIT+1]};

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_window_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             armed,
    input  logic [CNT_W-1:0] win,
    input  reload_t          reload,
    output logic [CNT_W-1:0] cnt,
    output logic             flag_set,
    output logic             rst_req
);

    logic arm_next, too_early, too_low, accept, timeout;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        arm_next  = armed || (reload.load && reload.arm);
        // the window test sees the count as it was before this write
        too_early = reload.load && arm_next && (cnt > win);
        accept    = reload.load && !too_early;
        too_low   = accept && arm_next && !reload.value[CNT_W-1];
        timeout   = armed && tick && !accept && (cnt == CNT_THRESH);
        flag_set  = tick && !accept && (cnt == CNT_THRESH + 1'b1);
        if (accept)    cnt_d = reload.value;
        else if (tick) cnt_d = cnt - 1'b1;
        else           cnt_d = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_TOP;
            rst_req <= 1'b0;
        end else begin
            cnt     <= cnt_d;
            rst_req <= too_early || too_low || timeout;
        end
    end

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_window_pkg::*;
#(
    parameter int BASE_DIV = 4096,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              ewi_irq
);

    logic             tick;
    logic             armed;
    logic             flag;
    logic             flag_set;
    logic [CNT_W-1:0] cnt;
    setup_t           setup;
    reload_t          reload;

    wdog_tick #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .psc  (setup.psc),
        .tick (tick)
    );

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt),
        .flag_set  (flag_set),
        .reload    (reload),
        .armed     (armed),
        .setup     (setup),
        .flag      (flag)
    );

    wdog_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .armed    (armed),
        .win      (setup.win),
        .reload   (reload),
        .cnt      (cnt),
        .flag_set (flag_set),
        .rst_req  (rst_req)
    );

    assign ewi_irq = setup.ewi && flag;

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdog_window_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic              armed,
    input logic              ewi,
    input logic              flag,
    input logic [CNT_W-1:0]  win,
    input logic              rst_req
);

    logic ctl_w;
    assign ctl_w = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFFS_CTRL));

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!ctl_w && !tick) |=> $stable(cnt));                                  // R2
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!ctl_w && tick) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));             // R2
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);                                                     // R3
    AST_TIMEOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        (armed && tick && !ctl_w && cnt == CNT_THRESH) |=> rst_req);          // R4
    AST_EARLY_REQ: assert property (@(posedge clk) disable iff (rst)
        (ctl_w && armed && cnt > win) |=> (rst_req && $stable(cnt) || rst_req && cnt == CNT_W'($past(cnt) - 1'b1))); // R6
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!armed && !(ctl_w && bus_wdata[CTRL_EN_BIT])) |=> !rst_req);         // R7
    AST_FLAG_AT_THRESH: assert property (@(posedge clk) disable iff (rst)
        (!ctl_w && tick && cnt == CNT_THRESH + 1'b1) |=> flag);               // R8
    AST_EWI_STICKY: assert property (@(posedge clk) disable iff (rst)
        ewi |=> ewi);                                                         // R10

endmodule

bind wdog_window wdog_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick      (tick),
    .cnt       (cnt),
    .armed     (armed),
    .ewi       (setup.ewi),
    .flag      (flag),
    .win       (setup.win),
    .rst_req   (rst_req)
);

// File: tb/wdog_window_tb.sv
module wdog_window_tb;

    localparam int BD  = 4;
    localparam int AW  = 4;
    localparam int DW  = 32;
    localparam logic [AW-1:0] A_CTRL = 4'h0;
    localparam logic [AW-1:0] A_CFG  = 4'h4;
    localparam logic [AW-1:0] A_STAT = 4'h8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rst_req;
    logic          ewi_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pulses = 0;

    always #10 clk = ~clk;

    wdog_window #(.BASE_DIV(BD), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .ewi_irq   (ewi_irq)
    );

    always @(negedge clk) if (!rst && rst_req) n_pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cnt(input int v, input string req);
        logic [DW-1:0] d;
        int guard = 0;
        rd(A_CTRL, d);
        while (int'(d[6:0]) != v && guard < 4000) begin
            @(negedge clk);
            rd(A_CTRL, d);
            guard++;
        end
        check(int'(d[6:0]) == v, req, int'(d[6:0]), v);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        do_reset();
        rd(A_CTRL, d); check(d == 32'h7F, "R1 ctrl", d, 32'h7F);
        rd(A_CFG, d);  check(d == 32'h7F, "R1 cfg", d, 32'h7F);
        rd(A_STAT, d); check(d == 32'h0, "R1 stat", d, 0);
        rd(4'hC, d);   check(d == 32'h0, "R1 hole", d, 0);
        check(!rst_req && !ewi_irq, "R1 outputs", {rst_req, ewi_irq}, 0);
    endtask

    task automatic t_rate();
        logic [DW-1:0] d;
        logic [6:0] c0;
        int per;
        do_reset();
        for (int s = 0; s < 4; s++) begin
            wr(A_CFG, (32'(s) << 7) | 32'h7F);
            rd(A_CTRL, d); c0 = d[6:0];
            while (d[6:0] == c0) begin @(negedge clk); rd(A_CTRL, d); end
            c0 = d[6:0];
            per = BD << s;
            repeat (per - 1) @(negedge clk);
            rd(A_CTRL, d); check(d[6:0] == c0, "R2 early", d[6:0], c0);
            @(negedge clk);
            rd(A_CTRL, d); check(d[6:0] == c0 - 7'd1, "R2 on time", d[6:0], c0 - 7'd1);
        end
    endtask

    task automatic t_disarmed();
        logic [DW-1:0] d;
        int p0;
        do_reset();
        p0 = n_pulses;
        wr(A_CTRL, 32'h05);
        rd(A_CTRL, d); check(d[7] == 1'b0, "R3 zero keeps disarmed", d[7], 0);
        check(d[6:0] == 7'h05, "R7 write accepted", d[6:0], 5);
        wait_cnt('h7F, "R2 wrap to top");
        wait_cnt('h3F, "R7 reach 0x3F");
        check(!rst_req, "R7 no timeout request", rst_req, 0);
        wr(A_CFG, 32'h00);
        wr(A_CTRL, 32'h70);
        rd(A_CTRL, d); check(d[6:0] == 7'h70, "R7 early write accepted", d[6:0], 'h70);
        wr(A_CTRL, 32'h10);
        rd(A_CTRL, d); check(d[6:0] == 7'h10, "R7 low write accepted", d[6:0], 'h10);
        @(negedge clk);
        check(n_pulses == p0, "R7 pulse count", n_pulses - p0, 0);
    endtask

    task automatic t_arm_sticky();
        logic [DW-1:0] d;
        int p0;
        do_reset();
        p0 = n_pulses;
        wr(A_CTRL, 32'hFF);
        rd(A_CTRL, d); check(d[7] == 1'b1, "R3 armed", d[7], 1);
        wr(A_CTRL, 32'h7F);
        rd(A_CTRL, d); check(d[7] == 1'b1, "R3 zero ignored", d[7], 1);
        check(d[6:0] == 7'h7F, "R6 reload at limit", d[6:0], 'h7F);
        @(negedge clk);
        check(n_pulses == p0, "R6 no request", n_pulses - p0, 0);
    endtask

    task automatic t_timeout();
        logic [DW-1:0] d;
        int p0;
        do_reset();
        wr(A_CTRL, 32'hFF);
        p0 = n_pulses;
        wait_cnt('h40, "R4 reach 0x40");
        rd(A_STAT, d); check(d[0] == 1'b1, "R8 flag without enable", d[0], 1);
        check(!ewi_irq, "R10 irq masked", ewi_irq, 0);
        check(!rst_req, "R4 none at 0x40", rst_req, 0);
        wait_cnt('h3F, "R4 reach 0x3F");
        check(rst_req, "R4 request with 0x3F", rst_req, 1);
        @(negedge clk); #1;
        check(!rst_req, "R4 one cycle", rst_req, 0);
        check(n_pulses - p0 == 1, "R4 pulse count", n_pulses - p0, 1);
    endtask

    task automatic t_window();
        logic [DW-1:0] d;
        logic [6:0] c0;
        do_reset();
        wr(A_CTRL, 32'hFF);
        wr(A_CFG, 32'h50);
        rd(A_CTRL, d); c0 = d[6:0];
        wr(A_CTRL, 32'hE0);
        check(rst_req, "R6 early request", rst_req, 1);
        rd(A_CTRL, d);
        check(d[6:0] != 7'h60 && (d[6:0] == c0 || d[6:0] == c0 - 7'd1),
              "R6 early not loaded", d[6:0], c0);
        wait_cnt('h50, "R6 reach limit");
        wr(A_CTRL, 32'hFF);
        check(!rst_req, "R6 boundary accepted", rst_req, 0);
        rd(A_CTRL, d); check(d[6:0] == 7'h7F, "R6 boundary loaded", d[6:0], 'h7F);
    endtask

    task automatic t_low_write();
        logic [DW-1:0] d;
        do_reset();
        wr(A_CTRL, 32'hBF);
        check(rst_req, "R5 low value request", rst_req, 1);
        rd(A_CTRL, d); check(d[6:0] == 7'h3F, "R5 value loaded", d[6:0], 'h3F);
    endtask

    task automatic t_warning();
        logic [DW-1:0] d;
        do_reset();
        wr(A_CFG, 32'h27F);
        wait_cnt('h40, "R8 reach 0x40");
        rd(A_STAT, d); check(d[0] == 1'b1, "R8 flag set", d[0], 1);
        check(ewi_irq, "R10 irq raised", ewi_irq, 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); check(d[0] == 1'b1, "R9 one ignored", d[0], 1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); check(d[0] == 1'b0, "R9 zero clears", d[0], 0);
        check(!ewi_irq, "R10 irq drops", ewi_irq, 0);
        wr(A_CFG, 32'h07F);
        rd(A_CFG, d); check(d == 32'h27F, "R10 enable sticky", d, 32'h27F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rate();
        t_disarmed();
        t_arm_sticky();
        t_timeout();
        t_window();
        t_low_write();
        t_warning();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule